// File: doc/BRIEF.md
# Lockable Flash Timing Prescaler

This block holds the 8-bit timing-control register of a flash controller and the prescaler that it drives. Software writes a 6-bit divisor so that the bus clock is divided down to about 1 MHz. The prescaler then produces a pulse one bus clock wide that paces the flash program and erase timing. Divisor code 0 suits a bus clock above 1.0 MHz and up to 1.6 MHz. Each further step of 1 MHz takes the next code, and code 0x18 covers a bus clock up to 25.6 MHz.

The register has two sticky status bits. The first records that software has written the register since reset. The second freezes the divisor field. Neither bit can be cleared except by reset. Writes must not reach the register while a flash command is in progress. If one does, it is dropped completely and a sticky error flag is raised. The flash controller waits for the valid output before it starts any command.

Top module: `flash_clkdiv`

## Requirements
- R1: Reads return {loaded, lock, divisor[5:0]}, with loaded at bit 7, lock at bit 6 and the divisor in bits 5 to 0. After reset the register reads 0x00, and wr_err and tick are 0.
- R2: The loaded flag goes to 1 on the first write accepted after reset, and it stays 1 until the next reset.
- R3: Once the lock bit is 1, it stays 1 until reset, and no later write changes the divisor.
- R4: A write that sets bit 6 while the register is unlocked also stores bits 5 to 0 of the same write as the new divisor. The lock takes effect after that write.
- R5: With divisor N and the loaded flag set, tick is high for exactly one cycle out of every N+1. After a write that stores a divisor, the first tick is high in the cycle that begins at the N-th rising edge after the write edge.
- R6: A write while cmd_busy is 1 changes no register bit and has no effect on tick timing. It sets wr_err, which stays 1 until reset.
- R7: A write with cmd_busy at 0 that the lock refuses still sets the loaded flag. It does not restart the prescaler.
- R8: div_valid equals the loaded flag. tick stays 0 while the loaded flag is 0.
- R9: Bit 7 of the write data is ignored, so writing 0 there never clears the loaded flag.
- R10: Every write that stores a divisor restarts the prescaler count from zero, even when the stored value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| cmd_busy | input | 1 | High while a flash command is executing |
| tick | output | 1 | Timing pulse, one cycle wide |
| div_loaded | output | 1 | Divider-loaded flag |
| div_valid | output | 1 | Divider valid for the flash controller |
| wr_err | output | 1 | Sticky flag for a write attempted while busy |

## Verification
The bench aims at three cases: a lock and a divisor written in the same word, writes that arrive after the lock is set, and writes that arrive while a command is busy. A design that applied the lock before the divisor would keep the old divisor. A design that let a busy write through would corrupt the divisor in the middle of a command. The bench also checks the tick cycle by cycle after each accepted write, including divisor 0 and rewrites of an unchanged value. A missing restart or an off-by-one in the terminal count shows up there as a shifted or lengthened tick period. Writes refused by the lock are expected to set the loaded flag without restarting the count, and a write with bit 7 low must never clear the loaded flag.

// File: rtl/flash_clkdiv_pkg.sv
package flash_clkdiv_pkg;
   localparam int unsigned DIV_W = 6;
   localparam int unsigned REG_W = DIV_W + 2;
   localparam int unsigned LOADED_BIT = REG_W - 1;
   localparam int unsigned LOCK_BIT   = REG_W - 2;

   typedef struct packed {
      logic             loaded;
      logic             lock;
      logic [DIV_W-1:0] divisor;
   } ctl_reg_t;
endpackage

// File: rtl/flash_clkdiv_regs.sv
module flash_clkdiv_regs
   import flash_clkdiv_pkg::*;
#(
   parameter int unsigned DW = DIV_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW+1:0] wr_data,
   input  logic          cmd_busy,
   output logic [DW-1:0] divisor,
   output logic          lock,
   output logic          loaded,
   output logic          wr_err,
   output logic          div_store
);
   localparam int unsigned LK = DW;

   initial begin
      assert (DW >= 1 && DW <= 16) else $error("DW out of range");
   end

   logic accept;
   assign accept    = wr_en && !cmd_busy;
   assign div_store = accept && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor <= '0;
         lock    <= 1'b0;
         loaded  <= 1'b0;
         wr_err  <= 1'b0;
      end else begin
         if (wr_en && cmd_busy) wr_err <= 1'b1;
         if (accept) loaded <= 1'b1;
         if (div_store) begin
            divisor <= wr_data[DW-1:0];
            lock    <= wr_data[LK];
         end
      end
   end

   p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);
   p_div_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(divisor));
   p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> loaded);
   p_busy_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd_busy) |=> ($stable(divisor) && $stable(lock) && wr_err));
endmodule

// File: rtl/flash_clkdiv_prescaler.sv
module flash_clkdiv_prescaler #(
   parameter int unsigned DW       = 6,
   parameter bit          GATE_OFF = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] divisor,
   input  logic          restart,
   input  logic          enable,
   output logic          tick
);
   initial begin
      assert (DW >= 1 && DW <= 16) else $error("DW out of range");
   end

   logic [DW-1:0] cnt;
   logic          at_tc;
   assign at_tc = (cnt == divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (at_tc)   cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   generate
      if (GATE_OFF) begin : g_gated
         assign tick = at_tc && enable;
      end else begin : g_free
         assign tick = at_tc;
      end
   endgenerate

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= divisor);
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor != '0 && !restart) |=> !tick);
endmodule

// File: rtl/flash_clkdiv.sv
module flash_clkdiv
   import flash_clkdiv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             cmd_busy,
   output logic             tick,
   output logic             div_loaded,
   output logic             div_valid,
   output logic             wr_err
);
   logic [DIV_W-1:0] divisor;
   logic             lock, loaded, div_store;
   ctl_reg_t         view;

   flash_clkdiv_regs #(.DW(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cmd_busy(cmd_busy), .divisor(divisor), .lock(lock),
      .loaded(loaded), .wr_err(wr_err), .div_store(div_store)
   );

   flash_clkdiv_prescaler #(.DW(DIV_W), .GATE_OFF(1'b1)) u_presc (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .restart(div_store),
      .enable(loaded), .tick(tick)
   );

   always_comb begin
      view.loaded  = loaded;
      view.lock    = lock;
      view.divisor = divisor;
   end
   assign rd_data    = view;
   assign div_loaded = loaded;
   assign div_valid  = loaded;

   p_no_tick_unloaded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !div_valid |-> !tick);
   p_lock_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cmd_busy && !rd_data[LOCK_BIT] && wr_data[LOCK_BIT])
      |=> (rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0]) && rd_data[LOCK_BIT]));
endmodule

// File: tb/flash_clkdiv_tb.sv
module flash_clkdiv_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       cmd_busy = 1'b0;
   logic [7:0] rd_data;
   logic       tick, div_loaded, div_valid, wr_err;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic [5:0] m_div = '0;
   logic       m_lock = 1'b0, m_loaded = 1'b0, m_err = 1'b0;
   int         m_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_clkdiv u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cmd_busy(cmd_busy), .tick(tick),
      .div_loaded(div_loaded), .div_valid(div_valid), .wr_err(wr_err)
   );

   function automatic logic [7:0] exp_reg();
      return {m_loaded, m_lock, m_div};
   endfunction

   function automatic logic exp_tick();
      return m_loaded && (m_cnt == int'(m_div));
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // model advance for one rising edge with current inputs
   task automatic model_step();
      logic store;
      store = wr_en && !cmd_busy && !m_lock;
      if (store || m_cnt == int'(m_div)) m_cnt = 0;
      else m_cnt = m_cnt + 1;
      if (wr_en && cmd_busy) m_err = 1'b1;
      if (wr_en && !cmd_busy) m_loaded = 1'b1;
      if (store) begin
         m_div  = wr_data[5:0];
         m_lock = wr_data[6];
      end
   endtask

   // one cycle: drive at negedge, model at posedge, compare at next negedge
   task automatic cycle(input logic we, input logic [7:0] d, input logic busy, input string req);
      wr_en = we; wr_data = d; cmd_busy = busy;
      @(posedge clk);
      model_step();
      @(negedge clk);
      wr_en = 1'b0;
      check({req, " reg"}, rd_data, exp_reg());
      check({req, " tick"}, tick, exp_tick());
      check({req, " valid"}, div_valid, m_loaded);
      check({req, " err"}, wr_err, m_err);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 1'b0, req);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int ticks;
      process::self().srandom(32'h5eed_1234);
      #(CLK_PERIOD * 2);
      @(negedge clk);
      // R1 reset state
      check("R1 reset reg", rd_data, 8'h00);
      check("R1 reset tick", tick, 1'b0);
      check("R1 reset err", wr_err, 1'b0);
      rst_n = 1'b1;
      // R8 no tick before loaded
      idle(5, "R8 unloaded");
      check("R8 valid low", div_valid, 1'b0);
      // R6 busy write ignored
      cycle(1'b1, 8'h43, 1'b1, "R6 busy write");
      check("R6 still unloaded", rd_data, 8'h00);
      check("R6 err sticky", wr_err, 1'b1);
      // R2/R5 divisor 3, count ticks over 16 cycles
      cycle(1'b1, 8'h03, 1'b0, "R2 first write");
      check("R2 loaded", div_loaded, 1'b1);
      ticks = 0;
      for (int i = 0; i < 16; i++) begin
         cycle(1'b0, 8'h00, 1'b0, "R5 period");
         ticks += int'(tick);
      end
      check("R5 four ticks in 16", ticks, 4);
      // R10 rewrite same value restarts
      idle(1, "R10 pre");
      cycle(1'b1, 8'h03, 1'b0, "R10 rewrite");
      idle(4, "R10 after");
      // divisor 0: tick every cycle; R9 bit7 ignored
      cycle(1'b1, 8'h00, 1'b0, "R9 bit7 zero");
      check("R9 loaded kept", div_loaded, 1'b1);
      idle(3, "R5 div0");
      check("R5 div0 tick", tick, 1'b1);
      // random unlocked phase, lock bit excluded
      for (int i = 0; i < 300; i++) begin
         logic [7:0] d;
         d = 8'($urandom) & 8'hBF;
         cycle(($urandom % 4) == 0, d, ($urandom % 5) == 0, "R5 random");
      end
      // R4 lock and divisor together
      cycle(1'b1, 8'h45, 1'b0, "R4 lock+div");
      check("R4 divisor applied", rd_data[5:0], 6'h05);
      check("R3 locked", rd_data[6], 1'b1);
      idle(2, "R4 after");
      // R7 refused write does not restart
      cycle(1'b1, 8'h02, 1'b0, "R7 refused");
      check("R7 divisor held", rd_data[5:0], 6'h05);
      // R3 random writes while locked
      for (int i = 0; i < 300; i++)
         cycle(($urandom % 3) == 0, 8'($urandom), ($urandom % 4) == 0, "R3 locked random");
      check("R3 divisor end", rd_data[5:0], 6'h05);
      // reset clears lock
      rst_n = 1'b0;
      m_div = '0; m_lock = 1'b0; m_loaded = 1'b0; m_err = 1'b0; m_cnt = 0;
      @(negedge clk);
      check("R1 reset again", rd_data, 8'h00);
      rst_n = 1'b1;
      cycle(1'b1, 8'h07, 1'b0, "R3 unlocked after reset");
      check("R3 writable", rd_data[5:0], 6'h07);
      idle(20, "R5 div7");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule